// File: doc/BRIEF.md
# Ping-Pong Transposing Frame Buffer

This block sits between two radix-8 stages of a 64-point transform pipeline. It holds two banks of 64 complex samples. The upstream stage fills one bank while the downstream stage drains the other. When a bank has been completely written and the other bank has been emptied, the roles of the two banks exchange.

Samples are written in arrival order, so write step n goes to address n. They are read through an 8×8 index transpose: read step k fetches address (k mod 8)·8 + k div 8. A frame that arrives in stride-8 order (0, 8, 16, …, 56, 1, 9, …) therefore leaves in natural order 0, 1, 2, …, 63. Arithmetic is not part of this block.

Both data sides are valid/ready streams. A sample moves on a clock edge where valid and ready are both high. `in_ready` is low only while the bank that would be written is still full, which means both banks hold frames that have not been read. A sender must keep a sample waiting until `in_ready` is high. Once `out_valid` is high, the buffer holds it high, and holds the offered sample steady, until `out_ready` accepts that sample.

Top module: `pp_xpose_buf`

## Requirements
- R1: After reset, `out_valid` and `out_sof` are 0 and `in_ready` is 1.
- R2: A sample is written only on an edge where `in_valid` and `in_ready` are both 1. A sample offered while `in_ready` is 0 is discarded and never appears at the output.
- R3: `out_valid` stays 0 until a full frame of 64 accepted samples has been written. It goes to 1 in the cycle after the edge that accepts the 64th sample of a frame, provided the read side was idle at that point.
- R4: Let the accepted samples of a frame be numbered n = 0..63 in arrival order. The k-th sample read from that frame (k = 0..63) is the sample with arrival number (k mod 8)·8 + k div 8.
- R5: `out_sof` is 1 with the first sample (k = 0) of each frame and 0 with every other sample. `out_sof` is never 1 while `out_valid` is 0.
- R6: While `out_valid` is 1 and `out_ready` is 0, on the next cycle `out_valid` is still 1 and `out_re`, `out_im` and `out_sof` are unchanged.
- R7: When both banks hold unread frames, `in_ready` is 0. It returns to 1 in the cycle after the last sample of the frame being read is accepted.
- R8: Writing one bank and reading the other happen in the same cycles. With `out_ready` held at 1 and samples sent back to back, `in_ready` never drops, and frames pass through at one sample per cycle.
- R9: Frames leave in the order in which they were written, and the two banks are used alternately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream sample valid |
| in_ready | output | 1 | Buffer can accept a sample |
| in_re | input | DATA_W | Real part of the incoming sample |
| in_im | input | DATA_W | Imaginary part of the incoming sample |
| out_valid | output | 1 | Outgoing sample valid |
| out_ready | input | 1 | Downstream accepts the sample |
| out_re | output | DATA_W | Real part of the outgoing sample |
| out_im | output | DATA_W | Imaginary part of the outgoing sample |
| out_sof | output | 1 | First sample of an outgoing frame |

## Verification
The assertions check, on every cycle, the properties that only relate flags to each other:
- no write lands in a full bank and no read comes from an empty bank;
- `in_ready` is low whenever both banks are full;
- `out_sof` appears only together with `out_valid`, and is present whenever `out_valid` rises;
- a stalled output holds valid, data and frame start steady.

Some properties need knowledge of the data and of sample counts, which only the bench's scenarios can show:
- the transposed order of the samples;
- the exact cycle in which a frame becomes readable;
- that samples offered during back-pressure are dropped;
- that frames keep their order across bank swaps;
- that overlapped write and read run without a stall.

// File: rtl/pp_xpose_pkg.sv
package pp_xpose_pkg;
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_t;

  function automatic bank_t other_bank(bank_t b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction
endpackage

// File: rtl/pp_wr_ctrl.sv
module pp_wr_ctrl
  import pp_xpose_pkg::*;
#(
  parameter int RADIX = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_fire,
  output logic [$clog2(RADIX*RADIX)-1:0]       wr_addr,
  output bank_t                                wr_bank,
  output logic                                 wr_last
);
  localparam int N  = RADIX * RADIX;
  localparam int AW = $clog2(N);

  logic [AW-1:0] cnt_q;
  bank_t         bank_q;

  // Write addresses follow arrival order.
  assign wr_addr = cnt_q;
  assign wr_bank = bank_q;
  assign wr_last = (cnt_q == AW'(N - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bank_q <= BANK_A;
    end else if (wr_fire) begin
      if (wr_last) begin
        cnt_q  <= '0;
        bank_q <= other_bank(bank_q);
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pp_rd_ctrl.sv
module pp_rd_ctrl
  import pp_xpose_pkg::*;
#(
  parameter int RADIX = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 rd_fire,
  output logic [$clog2(RADIX*RADIX)-1:0]       rd_addr,
  output bank_t                                rd_bank,
  output logic                                 rd_first,
  output logic                                 rd_last
);
  localparam int N  = RADIX * RADIX;
  localparam int AW = $clog2(N);
  localparam int LW = $clog2(RADIX);

  logic [AW-1:0] step_q;
  bank_t         bank_q;

  // Transpose: with RADIX a power of two, (k mod R)*R + k div R
  // is the low and high digit fields exchanged.
  assign rd_addr  = {step_q[LW-1:0], step_q[AW-1:LW]};
  assign rd_bank  = bank_q;
  assign rd_first = (step_q == '0);
  assign rd_last  = (step_q == AW'(N - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
      bank_q <= BANK_A;
    end else if (rd_fire) begin
      if (rd_last) begin
        step_q <= '0;
        bank_q <= other_bank(bank_q);
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pp_bank_track.sv
module pp_bank_track
  import pp_xpose_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_fire,
  input  logic       wr_last,
  input  bank_t      wr_bank,
  input  logic       rd_fire,
  input  logic       rd_last,
  input  bank_t      rd_bank,
  output logic [1:0] full
);
  logic [1:0] full_q;

  assign full = full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 2'b00;
    end else begin
      // The writer only fills an empty bank and the reader only
      // drains a full one, so the two updates never touch one bit.
      if (wr_fire && wr_last) full_q[wr_bank] <= 1'b1;
      if (rd_fire && rd_last) full_q[rd_bank] <= 1'b0;
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !full_q[wr_bank]);

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> full_q[rd_bank]);
endmodule

// File: rtl/pp_bank_store.sv
module pp_bank_store
  import pp_xpose_pkg::*;
#(
  parameter int SW    = 32,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  bank_t                    wr_bank,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [SW-1:0]            wr_data,
  input  bank_t                    rd_bank,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [SW-1:0]            rd_data
);
  logic [SW-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [SW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == bank_t'(b))) mem[wr_addr] <= wr_data;
    end

    assign bank_rd[b] = mem[rd_addr];
  end

  assign rd_data = bank_rd[rd_bank];
endmodule

// File: rtl/pp_xpose_buf.sv
module pp_xpose_buf
  import pp_xpose_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RADIX  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_re,
  input  logic [DATA_W-1:0] in_im,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_re,
  output logic [DATA_W-1:0] out_im,
  output logic              out_sof
);
  localparam int N  = RADIX * RADIX;
  localparam int AW = $clog2(N);
  localparam int SW = 2 * DATA_W;

  logic [AW-1:0] wr_addr, rd_addr;
  bank_t         wr_bank, rd_bank;
  logic          wr_last, rd_last, rd_first;
  logic          wr_fire, rd_fire;
  logic [1:0]    full;
  logic [SW-1:0] rd_data;

  assign in_ready  = !full[wr_bank];
  assign wr_fire   = in_valid && in_ready;
  assign out_valid = full[rd_bank];
  assign rd_fire   = out_valid && out_ready;
  assign out_sof   = out_valid && rd_first;
  assign out_re    = rd_data[SW-1:DATA_W];
  assign out_im    = rd_data[DATA_W-1:0];

  pp_wr_ctrl #(.RADIX(RADIX)) wr_i (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire),
    .wr_addr(wr_addr), .wr_bank(wr_bank), .wr_last(wr_last)
  );

  pp_rd_ctrl #(.RADIX(RADIX)) rd_i (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire),
    .rd_addr(rd_addr), .rd_bank(rd_bank), .rd_first(rd_first), .rd_last(rd_last)
  );

  pp_bank_track trk_i (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_last(wr_last), .wr_bank(wr_bank),
    .rd_fire(rd_fire), .rd_last(rd_last), .rd_bank(rd_bank),
    .full(full)
  );

  pp_bank_store #(.SW(SW), .DEPTH(N)) store_i (
    .clk(clk), .wr_en(wr_fire), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data({in_re, in_im}), .rd_bank(rd_bank), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  assert_both_full_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full == 2'b11) |-> !in_ready);

  assert_sof_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  assert_frame_opens_with_sof_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sof);

  assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_re) && $stable(out_im) && $stable(out_sof)));
endmodule

// File: tb/pp_xpose_buf_tb_top.sv
`timescale 1ns/1ps
module pp_xpose_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_re = '0;
  logic [15:0] in_im = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_re, out_im;
  logic        out_sof;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pp_xpose_buf dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im), .out_sof(out_sof)
  );

  // Vector table: frame seed and output stall pattern
  // (0 = always ready, 1 = ready low every third cycle, 2 = ready alternates).
  localparam logic [15:0] VEC_SEED  [4] = '{16'h0100, 16'h2000, 16'h7F00, 16'hC3A0};
  localparam int          VEC_STALL [4] = '{0, 1, 2, 0};

  function automatic logic [15:0] samp_re(logic [15:0] seed, int n);
    return seed + 16'(n * 7);
  endfunction
  function automatic logic [15:0] samp_im(logic [15:0] seed, int n);
    return seed ^ 16'(n * 13 + 5);
  endfunction
  function automatic int src_of(int k);
    return (k % 8) * 8 + k / 8;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Sends one frame. With stall_chk set, every cycle in which in_ready is 0
  // is counted as a failure of R8.
  task automatic write_frame(logic [15:0] seed, bit stall_chk);
    int n = 0;
    while (n < 64) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_re = samp_re(seed, n);
      in_im = samp_im(seed, n);
      if (stall_chk) check(in_ready == 1'b1, "R8", "in_ready during overlap", int'(in_ready), 1);
      if (in_ready) n++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic read_frame(logic [15:0] seed, int mode);
    int k = 0;
    int cyc = 0;
    bit held = 1'b0;
    logic [15:0] h_re = '0, h_im = '0;
    logic h_sof = 1'b0;
    while (k < 64) begin
      @(negedge clk);
      if (held) begin
        check(out_valid && out_re == h_re && out_im == h_im && out_sof == h_sof,
              "R6", "stalled output changed", int'(out_re), int'(h_re));
      end
      case (mode)
        1:       out_ready = (cyc % 3) != 2;
        2:       out_ready = cyc[0];
        default: out_ready = 1'b1;
      endcase
      cyc++;
      held = out_valid && !out_ready;
      h_re = out_re; h_im = out_im; h_sof = out_sof;
      if (out_valid && out_ready) begin
        check(out_re == samp_re(seed, src_of(k)), "R4", "out_re", int'(out_re), int'(samp_re(seed, src_of(k))));
        check(out_im == samp_im(seed, src_of(k)), "R4", "out_im", int'(out_im), int'(samp_im(seed, src_of(k))));
        check(out_sof == (k == 0), "R5", "out_sof", int'(out_sof), int'(k == 0));
        k++;
      end else if (!out_valid) begin
        check(out_sof == 1'b0, "R5", "sof without valid", int'(out_sof), 0);
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_sof == 1'b0, "R1", "outputs after reset", int'(out_valid), 0);

    // Table walk: one frame in, one frame out, per vector (R4, R5, R6, R9)
    for (int v = 0; v < 4; v++) begin
      write_frame(VEC_SEED[v], 1'b0);
      read_frame(VEC_SEED[v], VEC_STALL[v]);
    end

    // R3: readiness appears exactly after the 64th accepted sample
    for (int n = 0; n < 63; n++) begin
      @(negedge clk);
      in_valid = 1'b1; in_re = samp_re(16'h5500, n); in_im = samp_im(16'h5500, n);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R3", "valid after 63 samples", int'(out_valid), 0);
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R3", "valid with partial frame", int'(out_valid), 0);
    end
    in_valid = 1'b1; in_re = samp_re(16'h5500, 63); in_im = samp_im(16'h5500, 63);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R3", "valid after 64th sample", int'(out_valid), 1);
    check(out_sof == 1'b1, "R5", "sof on first sample", int'(out_sof), 1);

    // R7 / R2: second frame fills the other bank, then both are full
    write_frame(16'h0A0A, 1'b0);
    @(negedge clk);
    check(in_ready == 1'b0, "R7", "in_ready with both banks full", int'(in_ready), 0);
    repeat (5) begin
      in_valid = 1'b1; in_re = 16'hDEAD; in_im = 16'hBEEF;
      @(negedge clk);
      check(in_ready == 1'b0, "R7", "in_ready stays low", int'(in_ready), 0);
    end
    in_valid = 1'b0;
    // R9: frames leave in write order; R2: the discarded samples never appear
    read_frame(16'h5500, 0);
    check(in_ready == 1'b1, "R7", "in_ready after drain", int'(in_ready), 1);
    read_frame(16'h0A0A, 0);
    check(out_valid == 1'b0, "R2", "no frame from discarded samples", int'(out_valid), 0);

    // R8: overlapped writing and reading, three frames back to back
    fork
      begin
        write_frame(16'h1111, 1'b1);
        write_frame(16'h2222, 1'b1);
        write_frame(16'h3333, 1'b1);
      end
      begin
        read_frame(16'h1111, 0);
        read_frame(16'h2222, 0);
        read_frame(16'h3333, 0);
      end
    join
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R9", "idle after all frames", int'(out_valid), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule